// File: doc/BRIEF.md
# Branch Squash Arbiter with Upstream Redirect

This block sits in the branch-resolving stage of an in-order pipeline that can run several hardware threads. Each cycle it may receive several mispredicted-branch requests on parallel lanes. It decides, lane by lane, whether a request becomes a squash. A request is suppressed when an older branch of the same thread has already squashed in the same cycle. Each accepted squash is sent one cycle later on per-thread redirect outputs toward the earlier stages. Those outputs carry the mispredict, prediction-wrong and squash flags, the branch's own sequence number, the sequence number of its delay-slot instruction (the squash point), the predicted target and a taken indication.

The block keeps one record per thread: the most recent squash point and the cycle in which it was taken. An internal free-running counter supplies the current cycle. Branch lanes are evaluated in lane order, and lane 0 comes first. A later lane sees the record as already updated by earlier lanes in the same cycle. Instructions that the stage is about to forward are filtered against the record after all branch lanes are applied. An instruction younger than its thread's squash point from this cycle is removed. The survivors are packed toward slot 0, so a removed instruction takes no slot. Branch prediction and target computation happen elsewhere.

Top module: `branch_squash_gate`

## Requirements
- R1: After reset every redirect output is zero, and the first branch request of each thread is accepted.
- R2: One cycle after an accepted request on thread t, `rd_mispredict[t]`, `rd_pred_wrong[t]` and `rd_squash[t]` are 1. In the same cycle `rd_done_seq` slice t equals the branch sequence number and `rd_target` slice t equals the lane's predicted target.
- R3: `rd_squash_seq` slice t carries the delay-slot sequence number of the accepted branch, not the branch number.
- R4: `rd_taken[t]` is 1 exactly when the accepted branch's next-next PC differs from its next PC plus 4.
- R5: A request is ignored when its thread already squashed earlier in the same cycle (on a lower lane) with a squash point below the request's sequence number.
- R6: A later-lane request on a thread with a sequence number not above that thread's squash point from this cycle is accepted. Its fields then replace those of the earlier lane on the thread's outputs.
- R7: The redirect outputs of a thread are valid for exactly the one cycle after each cycle with an accepted request. In any other cycle all of that thread's flags and fields are 0.
- R8: A forward lane is dropped when its sequence number exceeds its thread's squash point recorded in the current cycle. Other threads, older instructions and squashes from earlier cycles never cause a drop.
- R9: Kept forward lanes appear on `fo_*` packed from slot 0 upward in their lane order, with unused slots zero.
- R10: Threads are independent: requests on different threads in the same cycle are all accepted.
- R11: The cycle counter never holds the all-ones value to which the per-thread cycle records reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | NB | Mispredicted-branch request per lane |
| br_tid | input | NB*TW | Thread of each branch lane |
| br_seq | input | NB*SEQW | Branch sequence number per lane |
| br_dslot_seq | input | NB*SEQW | Delay-slot sequence number per lane |
| br_target | input | NB*PCW | Predicted target per lane |
| br_npc | input | NB*PCW | Next PC per lane |
| br_nnpc | input | NB*PCW | Next-next PC per lane |
| fw_valid | input | NF | Instruction to forward per lane |
| fw_tid | input | NF*TW | Thread of each forward lane |
| fw_seq | input | NF*SEQW | Sequence number of each forward lane |
| fo_valid | output | NF | Kept forward slots, packed |
| fo_tid | output | NF*TW | Thread per kept slot |
| fo_seq | output | NF*SEQW | Sequence number per kept slot |
| rd_mispredict | output | NT | Per-thread mispredict flag |
| rd_pred_wrong | output | NT | Per-thread prediction-wrong flag |
| rd_squash | output | NT | Per-thread squash flag |
| rd_taken | output | NT | Per-thread branch-taken indication |
| rd_done_seq | output | NT*SEQW | Per-thread branch sequence number |
| rd_squash_seq | output | NT*SEQW | Per-thread squash point |
| rd_target | output | NT*PCW | Per-thread redirect PC |

## Verification
The embedded properties check every cycle that a raised squash flag always follows a request on that thread, and that a request on a thread with no same-cycle record is never lost. They also check that forward drops only happen in cycles with branch activity, that kept slots stay packed, and that the cycle counter avoids the reset marker. Whether the correct lane wins inside a cycle, and which sequence numbers, targets and taken values reach each thread, can only be shown by the bench. Its scenarios collide younger and older branches of one thread on different lanes and then compare every field against an independent model.

// File: rtl/branch_squash_gate.sv
module branch_squash_gate #(
  parameter int NT         = 4,
  parameter int NB         = 2,
  parameter int NF         = 3,
  parameter int SEQW       = 16,
  parameter int PCW        = 32,
  parameter int CYCW       = 32,
  parameter int INST_BYTES = 4,
  localparam int TW        = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NB-1:0]      br_valid,
  input  logic [NB*TW-1:0]   br_tid,
  input  logic [NB*SEQW-1:0] br_seq,
  input  logic [NB*SEQW-1:0] br_dslot_seq,
  input  logic [NB*PCW-1:0]  br_target,
  input  logic [NB*PCW-1:0]  br_npc,
  input  logic [NB*PCW-1:0]  br_nnpc,
  input  logic [NF-1:0]      fw_valid,
  input  logic [NF*TW-1:0]   fw_tid,
  input  logic [NF*SEQW-1:0] fw_seq,
  output logic [NF-1:0]      fo_valid,
  output logic [NF*TW-1:0]   fo_tid,
  output logic [NF*SEQW-1:0] fo_seq,
  output logic [NT-1:0]      rd_mispredict,
  output logic [NT-1:0]      rd_pred_wrong,
  output logic [NT-1:0]      rd_squash,
  output logic [NT-1:0]      rd_taken,
  output logic [NT*SEQW-1:0] rd_done_seq,
  output logic [NT*SEQW-1:0] rd_squash_seq,
  output logic [NT*PCW-1:0]  rd_target
);

  localparam logic [CYCW-1:0] CYC_NEVER = '1;
  localparam logic [CYCW-1:0] CYC_LAST  = CYC_NEVER - 1'b1;
  localparam logic [PCW-1:0]  STEP      = PCW'(INST_BYTES);

  logic [CYCW-1:0] cyc;
  logic [SEQW-1:0] rec_seq [NT];
  logic [CYCW-1:0] rec_cyc [NT];
  logic [SEQW-1:0] eff_seq [NT];
  logic [CYCW-1:0] eff_cyc [NT];

  logic [NT-1:0]   nx_sq, nx_taken, q_sq, q_taken;
  logic [SEQW-1:0] nx_done [NT];
  logic [SEQW-1:0] nx_sqs  [NT];
  logic [PCW-1:0]  nx_tgt  [NT];
  logic [SEQW-1:0] q_done  [NT];
  logic [SEQW-1:0] q_sqs   [NT];
  logic [PCW-1:0]  q_tgt   [NT];

  // branch lanes in priority order, each sees updates of lower lanes
  always_comb begin
    logic [TW-1:0]   bt;
    logic [SEQW-1:0] bs;
    logic [SEQW-1:0] bd;
    for (int t = 0; t < NT; t++) begin
      eff_seq[t] = rec_seq[t];
      eff_cyc[t] = rec_cyc[t];
      nx_done[t] = '0;
      nx_sqs[t]  = '0;
      nx_tgt[t]  = '0;
    end
    nx_sq    = '0;
    nx_taken = '0;
    for (int b = 0; b < NB; b++) begin
      bt = br_tid[b*TW +: TW];
      bs = br_seq[b*SEQW +: SEQW];
      bd = br_dslot_seq[b*SEQW +: SEQW];
      if (br_valid[b] && !(eff_cyc[bt] == cyc && eff_seq[bt] < bs)) begin
        eff_seq[bt]  = bd;
        eff_cyc[bt]  = cyc;
        nx_sq[bt]    = 1'b1;
        nx_done[bt]  = bs;
        nx_sqs[bt]   = bd;
        nx_tgt[bt]   = br_target[b*PCW +: PCW];
        nx_taken[bt] = br_nnpc[b*PCW +: PCW] != (br_npc[b*PCW +: PCW] + STEP);
      end
    end
  end

  // forward filter with compaction
  always_comb begin
    logic [TW-1:0]   ft;
    logic [SEQW-1:0] fs;
    int k;
    k        = 0;
    fo_valid = '0;
    fo_tid   = '0;
    fo_seq   = '0;
    for (int f = 0; f < NF; f++) begin
      ft = fw_tid[f*TW +: TW];
      fs = fw_seq[f*SEQW +: SEQW];
      if (fw_valid[f] && !(eff_cyc[ft] == cyc && fs > eff_seq[ft])) begin
        fo_valid[k]          = 1'b1;
        fo_tid[k*TW +: TW]   = ft;
        fo_seq[k*SEQW +: SEQW] = fs;
        k = k + 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc     <= '0;
      q_sq    <= '0;
      q_taken <= '0;
      for (int t = 0; t < NT; t++) begin
        rec_seq[t] <= '0;
        rec_cyc[t] <= CYC_NEVER;
        q_done[t]  <= '0;
        q_sqs[t]   <= '0;
        q_tgt[t]   <= '0;
      end
    end else begin
      cyc     <= (cyc == CYC_LAST) ? '0 : cyc + 1'b1;
      q_sq    <= nx_sq;
      q_taken <= nx_taken;
      for (int t = 0; t < NT; t++) begin
        rec_seq[t] <= eff_seq[t];
        rec_cyc[t] <= eff_cyc[t];
        q_done[t]  <= nx_done[t];
        q_sqs[t]   <= nx_sqs[t];
        q_tgt[t]   <= nx_tgt[t];
      end
    end
  end

  assign rd_mispredict = q_sq;
  assign rd_pred_wrong = q_sq;
  assign rd_squash     = q_sq;
  assign rd_taken      = q_taken;

  logic [NT-1:0] hit_port;
  always_comb begin
    hit_port = '0;
    for (int b = 0; b < NB; b++)
      if (br_valid[b]) hit_port[br_tid[b*TW +: TW]] = 1'b1;
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign rd_done_seq[t*SEQW +: SEQW]   = q_done[t];
    assign rd_squash_seq[t*SEQW +: SEQW] = q_sqs[t];
    assign rd_target[t*PCW +: PCW]       = q_tgt[t];

    AST_FLAG_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      rd_squash[t] |-> $past(hit_port[t])); // R7
    AST_FRESH_THREAD_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit_port[t]) && $past(rec_cyc[t] != cyc)) |-> rd_squash[t]); // R1
  end

  AST_CYC_AVOIDS_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    cyc != CYC_NEVER); // R11
  AST_DROP_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fo_valid) < $countones(fw_valid)) |-> (|br_valid)); // R8
  AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_valid & (fo_valid + 1'b1)) == '0); // R9

endmodule

// File: tb/test_branch_squash_gate.sv
`timescale 1ns/1ps
module test_branch_squash_gate;
  localparam int NT = 4, NB = 2, NF = 3, SEQW = 16, PCW = 32, TW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] br_valid = '0;
  logic [NB*TW-1:0] br_tid = '0;
  logic [NB*SEQW-1:0] br_seq = '0, br_dslot_seq = '0;
  logic [NB*PCW-1:0] br_target = '0, br_npc = '0, br_nnpc = '0;
  logic [NF-1:0] fw_valid = '0;
  logic [NF*TW-1:0] fw_tid = '0;
  logic [NF*SEQW-1:0] fw_seq = '0;
  logic [NF-1:0] fo_valid;
  logic [NF*TW-1:0] fo_tid;
  logic [NF*SEQW-1:0] fo_seq;
  logic [NT-1:0] rd_mispredict, rd_pred_wrong, rd_squash, rd_taken;
  logic [NT*SEQW-1:0] rd_done_seq, rd_squash_seq;
  logic [NT*PCW-1:0] rd_target;

  always #2.5 clk = ~clk;

  branch_squash_gate i_branch_squash_gate (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_tid(br_tid), .br_seq(br_seq),
    .br_dslot_seq(br_dslot_seq), .br_target(br_target), .br_npc(br_npc), .br_nnpc(br_nnpc),
    .fw_valid(fw_valid), .fw_tid(fw_tid), .fw_seq(fw_seq), .fo_valid(fo_valid),
    .fo_tid(fo_tid), .fo_seq(fo_seq), .rd_mispredict(rd_mispredict),
    .rd_pred_wrong(rd_pred_wrong), .rd_squash(rd_squash), .rd_taken(rd_taken),
    .rd_done_seq(rd_done_seq), .rd_squash_seq(rd_squash_seq), .rd_target(rd_target));

  int nchecks = 0, nfail = 0;
  bit finished = 0;
  logic [NT-1:0] e_sq, e_tk;
  logic [SEQW-1:0] e_done [NT];
  logic [SEQW-1:0] e_sqs [NT];
  logic [PCW-1:0] e_tgt [NT];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_br(int b, bit v, int tid, int seq, int ds, logic [PCW-1:0] tgt,
                        logic [PCW-1:0] npc, logic [PCW-1:0] nnpc);
    br_valid[b] = v;
    br_tid[b*TW +: TW] = TW'(tid);
    br_seq[b*SEQW +: SEQW] = SEQW'(seq);
    br_dslot_seq[b*SEQW +: SEQW] = SEQW'(ds);
    br_target[b*PCW +: PCW] = tgt;
    br_npc[b*PCW +: PCW] = npc;
    br_nnpc[b*PCW +: PCW] = nnpc;
  endtask

  task automatic set_fw(int f, bit v, int tid, int seq);
    fw_valid[f] = v;
    fw_tid[f*TW +: TW] = TW'(tid);
    fw_seq[f*SEQW +: SEQW] = SEQW'(seq);
  endtask

  task automatic idle();
    for (int b = 0; b < NB; b++) set_br(b, 0, 0, 0, 0, '0, '0, '0);
    for (int f = 0; f < NF; f++) set_fw(f, 0, 0, 0);
  endtask

  function automatic bit is_taken(logic [PCW-1:0] npc, logic [PCW-1:0] nnpc);
    return nnpc != npc + 32'd4;
  endfunction

  // inputs set at negedge; checks this cycle's forward view, then next cycle's redirect
  task automatic step();
    bit sq_now [NT];
    logic [SEQW-1:0] sq_pt [NT];
    logic [NF-1:0] x_v;
    logic [NF*TW-1:0] x_t;
    logic [NF*SEQW-1:0] x_s;
    int k;
    #1;
    e_sq = '0; e_tk = '0;
    for (int t = 0; t < NT; t++) begin
      sq_now[t] = 0; sq_pt[t] = '0; e_done[t] = '0; e_sqs[t] = '0; e_tgt[t] = '0;
    end
    for (int b = 0; b < NB; b++) begin
      int t;
      logic [SEQW-1:0] s;
      t = int'(br_tid[b*TW +: TW]);
      s = br_seq[b*SEQW +: SEQW];
      if (br_valid[b] && !(sq_now[t] && sq_pt[t] < s)) begin
        sq_now[t] = 1; sq_pt[t] = br_dslot_seq[b*SEQW +: SEQW];
        e_sq[t] = 1'b1; e_done[t] = s; e_sqs[t] = sq_pt[t];
        e_tgt[t] = br_target[b*PCW +: PCW];
        e_tk[t] = is_taken(br_npc[b*PCW +: PCW], br_nnpc[b*PCW +: PCW]);
      end
    end
    x_v = '0; x_t = '0; x_s = '0; k = 0;
    for (int f = 0; f < NF; f++) begin
      int t;
      logic [SEQW-1:0] s;
      t = int'(fw_tid[f*TW +: TW]);
      s = fw_seq[f*SEQW +: SEQW];
      if (fw_valid[f] && !(sq_now[t] && s > sq_pt[t])) begin
        x_v[k] = 1'b1; x_t[k*TW +: TW] = TW'(t); x_s[k*SEQW +: SEQW] = s; k++;
      end
    end
    chk(fo_valid == x_v, "R8 fo_valid", 64'(fo_valid), 64'(x_v));
    chk(fo_seq == x_s && fo_tid == x_t, "R9 fo_seq/fo_tid", 64'(fo_seq), 64'(x_s));
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      chk(rd_squash[t] == e_sq[t] && rd_mispredict[t] == e_sq[t] && rd_pred_wrong[t] == e_sq[t],
          "R2 R5 R6 R7 R10 flags", 64'({rd_mispredict[t], rd_pred_wrong[t], rd_squash[t]}),
          64'({3{e_sq[t]}}));
      chk(rd_done_seq[t*SEQW +: SEQW] == e_done[t] && rd_target[t*PCW +: PCW] == e_tgt[t],
          "R2 done/target", {rd_done_seq[t*SEQW +: SEQW], rd_target[t*PCW +: PCW]},
          {e_done[t], e_tgt[t]});
      chk(rd_squash_seq[t*SEQW +: SEQW] == e_sqs[t], "R3 squash_seq",
          64'(rd_squash_seq[t*SEQW +: SEQW]), 64'(e_sqs[t]));
      chk(rd_taken[t] == e_tk[t], "R4 taken", 64'(rd_taken[t]), 64'(e_tk[t]));
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nchecks++; nfail++;
      $display("FAIL watchdog act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(rd_squash == '0 && rd_mispredict == '0 && rd_pred_wrong == '0 && rd_taken == '0 &&
        rd_done_seq == '0 && rd_squash_seq == '0 && rd_target == '0, "R1 reset",
        64'(rd_squash), 64'(0));
    // R1 R11: first squash of thread 2 accepted, not-taken sequential path
    set_br(0, 1, 2, 9, 10, 32'h0000_4000, 32'h100, 32'h104);
    step();
    // R5: younger branch on lane 1 same thread is ignored, forward drop of younger insts (R8)
    idle();
    set_br(0, 1, 1, 5, 6, 32'h0000_8000, 32'h200, 32'h300);
    set_br(1, 1, 1, 8, 9, 32'h0000_9000, 32'h210, 32'h214);
    set_fw(0, 1, 1, 7); set_fw(1, 1, 1, 6); set_fw(2, 1, 0, 12);
    step();
    // R8: squash of a previous cycle no longer drops
    idle();
    set_fw(0, 1, 1, 7); set_fw(1, 1, 1, 20);
    step();
    // R6: older branch on lane 1 overrides lane 0
    idle();
    set_br(0, 1, 3, 12, 13, 32'h0000_A000, 32'h400, 32'h404);
    set_br(1, 1, 3, 4, 5, 32'h0000_B000, 32'h500, 32'h600);
    set_fw(0, 1, 3, 6); set_fw(1, 1, 3, 5); set_fw(2, 1, 2, 40);
    step();
    // R10: two threads in one cycle
    idle();
    set_br(0, 1, 0, 30, 31, 32'h0000_C000, 32'h700, 32'h704);
    set_br(1, 1, 2, 31, 32, 32'h0000_D000, 32'h800, 32'h900);
    step();
    // R7: quiet cycle returns everything to zero
    idle();
    step();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      for (int b = 0; b < NB; b++) begin
        int s;
        logic [PCW-1:0] npc;
        s = $urandom_range(0, 15);
        npc = {$urandom} & 32'hFFFF_FFFC;
        set_br(b, $urandom_range(0, 2) != 0, $urandom_range(0, NT-1), s, s + 1, $urandom,
               npc, ($urandom_range(0, 1) != 0) ? npc + 32'd4 : {$urandom});
      end
      for (int f = 0; f < NF; f++)
        set_fw(f, $urandom_range(0, 3) != 0, $urandom_range(0, NT-1), $urandom_range(0, 20));
      step();
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule